// File: doc/BRIEF.md
# Segmented Waveform RAM Playback Controller

This block owns a small waveform memory and the logic that plays it back. A host programs it through a register port with a short address, a write strobe and a read strobe. Two segment profiles each hold a start location, an end location, a step interval and a mode code. A control word holds the memory enable bit and a two-bit destination field. All of these host writes land in shadow copies. A separate update strobe copies every shadow value into the active bank in a single cycle.

An external trigger line is synchronized inside the block. The direction of each transition picks the segment profile: a rising edge picks profile 0 and a falling edge picks profile 1. Any transition also restarts the playback engine. While the memory enable is clear, the host loads and reads waveform words through one data register. Each access moves an internal pointer through the selected segment's address span. While the enable is set, playback runs in ramp-up mode. It emits an address and its stored word, advances one location per step interval and raises a done flag at the end location.

Top module: `wavePlayCtl`

## Requirements
- R1: After reset, the control word reads 0 (enable clear, destination 0). Both segment words read 1: step interval 1, start 0, end 0, mode 0. Playback is inactive, done is low, the segment index is 0 and the playback address is 0.
- R2: Register addresses are: 0 for the control word (bit 0 enable, bits 2:1 destination), 1 for segment 0, 2 for segment 1, 3 for the waveform data register. A segment word packs step interval in bits 7:0, start in bits 11:8, end in bits 15:12 and mode in bits 18:16. The segment index reads 0 after a rising trigger edge and 1 after a falling one. It is valid three clock edges after the edge that first samples the new trigger level.
- R3: With enable set and the selected mode equal to 1, any trigger transition starts playback at the selected segment's start address. The start is seen after the fourth clock edge from the one that samples the new level.
- R4: Writes to the control and segment words change nothing in operation until an update strobe. A trigger-driven pointer reload that follows such a write still uses the old active values.
- R5: With enable set and mode 1 in the active bank, an update strobe starts playback of the selected segment one edge after the strobe is sampled.
- R6: While the active enable is clear, playback stays inactive. While it is set, writes to and reads of the data register have no effect: reads return 0, and the memory and the pointer are left unchanged.
- R7: In playback, each address is held for the step interval in clock cycles, with 0 treated as 1. After the end address has been held, playback stops and done goes high. The data output shows the word stored at the playback address.
- R8: The host pointer loads the active start address on each update strobe or trigger transition. Each data register access uses the pointer and then advances it by one. After the end address it wraps back to the start. When start equals end, only one location is touched.
- R9: A mode code other than 1 leaves playback inactive and done low after a restart.
- R10: A register read returns its value one clock edge after the read strobe is sampled. Reads of the control and segment words return the shadow contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Registered read data |
| updIn | input | 1 | Update strobe: shadow to active |
| trigIn | input | 1 | Asynchronous trigger line |
| segIdx | output | 1 | Currently selected segment profile |
| playDest | output | 2 | Active destination field |
| playAddr | output | 4 | Playback address |
| playData | output | 16 | Word stored at the playback address |
| playActive | output | 1 | Playback running |
| playDone | output | 1 | Playback reached its end address |

## Verification
Each result has a fixed latency, and every check is sampled on the falling clock edge that matches it. Read data is due after the first rising edge that follows the read strobe. An update restarts the engine on the next edge after it is sampled, so the first playback address appears one falling edge after the strobe is removed. A trigger level change needs three edges before the segment index moves and a fourth before playback or a pointer reload is seen. The bench then checks the playback address on every single falling edge. It expects exactly one step interval per location, followed by done on the next falling edge.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_RAMP_UP = 3'd1;
  localparam int NUM_SEG = 2;
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_SEG_BASE = 2'd1;
  localparam logic [1:0] REG_DATA = 2'd3;

  typedef struct packed {
    logic restart;    // reload pointer, re-evaluate playback
    logic startPlay;  // begin ramp-up playback of selected segment
  } wpcStrobe_t;
endpackage

// File: rtl/wpc_ctrl.sv
module wpc_ctrl
  import wpc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int STEP_W = 8,
  parameter int HOST_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [HOST_W-1:0] regWrData,
  input  logic              updIn,
  input  logic              trigIn,
  output wpcStrobe_t        strobe,
  output logic              ramEn,
  output logic [1:0]        playDest,
  output logic              segSel,
  output logic [ADDR_W-1:0] selStart,
  output logic [ADDR_W-1:0] selEnd,
  output logic [STEP_W-1:0] selStep,
  output logic [HOST_W-1:0] cfgRdWord
);
  localparam int CFG_W = STEP_W + 2 * ADDR_W + MODE_W;
  localparam int START_LSB = STEP_W;
  localparam int END_LSB = STEP_W + ADDR_W;
  localparam int MODE_LSB = STEP_W + 2 * ADDR_W;
  localparam logic [CFG_W-1:0] SEG_RESET = CFG_W'(1);

  logic [CFG_W-1:0] shadowSeg [NUM_SEG];
  logic [CFG_W-1:0] activeSeg [NUM_SEG];
  logic [2:0]       shadowCtrl;
  logic [2:0]       activeCtrl;

  // shadow bank
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowCtrl <= '0;
      for (int i = 0; i < NUM_SEG; i++) shadowSeg[i] <= SEG_RESET;
    end else if (regWrEn) begin
      if (regAddr == REG_CTRL) shadowCtrl <= regWrData[2:0];
      for (int i = 0; i < NUM_SEG; i++)
        if (regAddr == REG_SEG_BASE + 2'(i)) shadowSeg[i] <= regWrData[CFG_W-1:0];
    end
  end

  // active bank, committed by update strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeCtrl <= '0;
      for (int i = 0; i < NUM_SEG; i++) activeSeg[i] <= SEG_RESET;
    end else if (updIn) begin
      activeCtrl <= shadowCtrl;
      for (int i = 0; i < NUM_SEG; i++) activeSeg[i] <= shadowSeg[i];
    end
  end

  always_comb begin
    cfgRdWord = '0;
    if (regAddr == REG_CTRL) cfgRdWord = HOST_W'(shadowCtrl);
    for (int i = 0; i < NUM_SEG; i++)
      if (regAddr == REG_SEG_BASE + 2'(i)) cfgRdWord = HOST_W'(shadowSeg[i]);
  end

  // trigger synchronizer and edge detection
  logic syncA, syncB, syncLast, edgeDet, trigPulse, updPulse;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      syncLast <= 1'b0;
    end else begin
      syncA <= trigIn;
      syncB <= syncA;
      syncLast <= syncB;
    end
  end
  assign edgeDet = syncB ^ syncLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigPulse <= 1'b0;
      segSel <= 1'b0;
      updPulse <= 1'b0;
    end else begin
      trigPulse <= edgeDet;
      updPulse <= updIn;
      if (edgeDet) segSel <= ~syncB;  // rising -> 0, falling -> 1
    end
  end

  logic [CFG_W-1:0] selWord;
  assign selWord = activeSeg[segSel];
  assign selStep = selWord[STEP_W-1:0];
  assign selStart = selWord[START_LSB +: ADDR_W];
  assign selEnd = selWord[END_LSB +: ADDR_W];

  assign ramEn = activeCtrl[0];
  assign playDest = activeCtrl[2:1];

  always_comb begin
    strobe.restart = trigPulse | updPulse;
    strobe.startPlay = (trigPulse | updPulse) & ramEn &
                       (selWord[MODE_LSB +: MODE_W] == MODE_RAMP_UP);
  end

  AST_RISE_SEG0: assert property (@(posedge clk) disable iff (!rstN)
    (edgeDet && syncB) |=> (trigPulse && segSel == 1'b0)); // R2
  AST_FALL_SEG1: assert property (@(posedge clk) disable iff (!rstN)
    (edgeDet && !syncB) |=> (trigPulse && segSel == 1'b1)); // R2
  AST_NO_EDGE_NO_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    !edgeDet |=> !trigPulse); // R3
  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !updIn |=> ($stable(activeSeg[0]) && $stable(activeSeg[1]) && $stable(activeCtrl))); // R4
endmodule

// File: rtl/wpc_dpath.sv
module wpc_dpath
  import wpc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int STEP_W = 8,
  parameter int HOST_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  wpcStrobe_t        strobe,
  input  logic              ramEn,
  input  logic [ADDR_W-1:0] segStart,
  input  logic [ADDR_W-1:0] segEnd,
  input  logic [STEP_W-1:0] segStep,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [HOST_W-1:0] regWrData,
  input  logic [HOST_W-1:0] cfgRdWord,
  output logic [HOST_W-1:0] regRdData,
  output logic [ADDR_W-1:0] playAddr,
  output logic [DATA_W-1:0] playData,
  output logic              playActive,
  output logic              playDone
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ram [DEPTH];
  logic [ADDR_W-1:0] hostPtr;
  logic              dataSel, hostWr, hostRd, hostAcc;
  logic [STEP_W-1:0] stepCnt, effStep;
  logic              lastTick;

  assign dataSel = (regAddr == REG_DATA);
  assign hostWr = regWrEn && dataSel && !ramEn;
  assign hostRd = regRdEn && !regWrEn && dataSel && !ramEn;
  assign hostAcc = hostWr || hostRd;

  // host access pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hostPtr <= '0;
    else if (strobe.restart) hostPtr <= segStart;
    else if (hostAcc) hostPtr <= (hostPtr == segEnd) ? segStart : hostPtr + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) ram[i] <= '0;
    end else if (hostWr) begin
      ram[hostPtr] <= regWrData[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regRdData <= '0;
    else if (regRdEn && !regWrEn) begin
      if (dataSel) regRdData <= ramEn ? '0 : HOST_W'(ram[hostPtr]);
      else regRdData <= cfgRdWord;
    end
  end

  // ramp-up playback
  assign effStep = (segStep == '0) ? STEP_W'(1) : segStep;
  assign lastTick = (stepCnt == effStep - STEP_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      playActive <= 1'b0;
      playDone <= 1'b0;
      playAddr <= '0;
      stepCnt <= '0;
    end else if (strobe.restart) begin
      playActive <= strobe.startPlay;
      playDone <= 1'b0;
      stepCnt <= '0;
      if (strobe.startPlay) playAddr <= segStart;
    end else if (!ramEn) begin
      playActive <= 1'b0;
    end else if (playActive) begin
      if (lastTick) begin
        stepCnt <= '0;
        if (playAddr == segEnd) begin
          playActive <= 1'b0;
          playDone <= 1'b1;
        end else begin
          playAddr <= playAddr + ADDR_W'(1);
        end
      end else begin
        stepCnt <= stepCnt + STEP_W'(1);
      end
    end
  end

  assign playData = ram[playAddr];

  AST_STEP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (playActive && ramEn && !strobe.restart && !lastTick) |=> $stable(playAddr)); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    playDone |-> !playActive); // R7
  AST_DIS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !ramEn |=> !playActive); // R6
  AST_EN_BLOCKS_HOST: assert property (@(posedge clk) disable iff (!rstN)
    (ramEn && (regWrEn || regRdEn) && dataSel && !strobe.restart) |=> $stable(hostPtr)); // R6
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (hostAcc && !strobe.restart && hostPtr == segEnd) |=> (hostPtr == $past(segStart))); // R8
endmodule

// File: rtl/wavePlayCtl.sv
module wavePlayCtl
  import wpc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int STEP_W = 8,
  parameter int HOST_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [HOST_W-1:0] regWrData,
  output logic [HOST_W-1:0] regRdData,
  input  logic              updIn,
  input  logic              trigIn,
  output logic              segIdx,
  output logic [1:0]        playDest,
  output logic [ADDR_W-1:0] playAddr,
  output logic [DATA_W-1:0] playData,
  output logic              playActive,
  output logic              playDone
);
  wpcStrobe_t        strobe;
  logic              ramEn;
  logic [ADDR_W-1:0] selStart, selEnd;
  logic [STEP_W-1:0] selStep;
  logic [HOST_W-1:0] cfgRdWord;

  wpc_ctrl #(.ADDR_W(ADDR_W), .STEP_W(STEP_W), .HOST_W(HOST_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .updIn(updIn), .trigIn(trigIn), .strobe(strobe),
    .ramEn(ramEn), .playDest(playDest), .segSel(segIdx), .selStart(selStart),
    .selEnd(selEnd), .selStep(selStep), .cfgRdWord(cfgRdWord)
  );

  wpc_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP_W(STEP_W), .HOST_W(HOST_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ramEn(ramEn), .segStart(selStart),
    .segEnd(selEnd), .segStep(selStep), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .cfgRdWord(cfgRdWord),
    .regRdData(regRdData), .playAddr(playAddr), .playData(playData),
    .playActive(playActive), .playDone(playDone)
  );
endmodule

// File: tb/wavePlayCtl_tb.sv
module wavePlayCtl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        updIn = 1'b0, trigIn = 1'b0;
  logic        segIdx;
  logic [1:0]  playDest;
  logic [3:0]  playAddr;
  logic [15:0] playData;
  logic        playActive, playDone;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  wavePlayCtl dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .updIn(updIn), .trigIn(trigIn),
    .segIdx(segIdx), .playDest(playDest), .playAddr(playAddr), .playData(playData),
    .playActive(playActive), .playDone(playDone)
  );

  function automatic logic [31:0] mkSeg(int step, int startA, int endA, int mode);
    return {13'd0, 3'(mode), 4'(endA), 4'(startA), 8'(step)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); regRdEn = 1'b1; regAddr = a;
    @(negedge clk); regRdEn = 1'b0; v = regRdData;
  endtask

  task automatic doUpdate();
    @(negedge clk); updIn = 1'b1;
    @(negedge clk); updIn = 1'b0;
  endtask

  task automatic doTrig(input logic lvl);
    @(negedge clk); trigIn = lvl;
    repeat (3) @(negedge clk);
  endtask

  task automatic checkPlay(input int startA, input int endA, input int step, input string req);
    int eff;
    eff = (step == 0) ? 1 : step;
    for (int a = startA; a <= endA; a++)
      for (int c = 0; c < eff; c++) begin
        @(negedge clk);
        check(playActive && playAddr == 4'(a), req, {27'd0, playActive, playAddr}, {27'd0, 1'b1, 4'(a)});
      end
    @(negedge clk);
    check(!playActive && playDone, req, {30'd0, playActive, playDone}, 32'd1);
  endtask

  task automatic testReset();
    logic [31:0] v;
    check(!playActive && !playDone && segIdx == 1'b0 && playAddr == 4'd0, "R1 outputs",
          {26'd0, playActive, playDone, playAddr}, 32'd0);
    rdReg(2'd0, v); check(v == 32'd0, "R1 control word", v, 32'd0);
    rdReg(2'd1, v); check(v == 32'd1, "R1 segment 0 word", v, 32'd1);
    rdReg(2'd2, v); check(v == 32'd1, "R1 segment 1 word", v, 32'd1);
  endtask

  task automatic testLoad();
    logic [31:0] v;
    wrReg(2'd1, mkSeg(1, 2, 5, 1));
    doUpdate();
    @(negedge clk);
    check(!playActive, "R6 idle when disabled", {31'd0, playActive}, 32'd0);
    for (int i = 0; i < 4; i++) wrReg(2'd3, 32'hA000 + 32'(i));
    for (int i = 0; i < 4; i++) begin
      rdReg(2'd3, v);
      check(v == 32'hA000 + 32'(i), "R8 walk start to end", v, 32'hA000 + 32'(i));
    end
    rdReg(2'd3, v);
    check(v == 32'hA000, "R8 wrap to start", v, 32'hA000);
  endtask

  task automatic testShadow();
    logic [31:0] v;
    wrReg(2'd1, mkSeg(1, 7, 7, 1));
    doTrig(1'b1);
    rdReg(2'd3, v);
    check(v == 32'hA000, "R4 shadow not yet active", v, 32'hA000);
    doUpdate();
    wrReg(2'd3, 32'h5A5A);
    rdReg(2'd3, v); check(v == 32'h5A5A, "R8 single location read 1", v, 32'h5A5A);
    rdReg(2'd3, v); check(v == 32'h5A5A, "R8 single location read 2", v, 32'h5A5A);
  endtask

  task automatic testUpdatePlay();
    logic [31:0] v;
    wrReg(2'd1, mkSeg(1, 0, 3, 1));
    wrReg(2'd2, mkSeg(3, 10, 11, 1));
    rdReg(2'd2, v);
    check(v == mkSeg(3, 10, 11, 1), "R10 shadow readback", v, mkSeg(3, 10, 11, 1));
    wrReg(2'd0, 32'h5);
    @(negedge clk);
    check(!playActive && playDest == 2'd0, "R4 control not yet active",
          {29'd0, playActive, playDest}, 32'd0);
    doUpdate();
    check(playDest == 2'd2, "R4 destination after update", {30'd0, playDest}, 32'd2);
    checkPlay(0, 3, 1, "R5 R7 update-started ramp");
    check(playData == 16'hA001, "R7 data at playback address", {16'd0, playData}, 32'hA001);
  endtask

  task automatic testIgnored();
    logic [31:0] v;
    wrReg(2'd3, 32'hBEEF);
    rdReg(2'd3, v);
    check(v == 32'd0, "R6 data read ignored while enabled", v, 32'd0);
  endtask

  task automatic testTrigFall();
    doTrig(1'b0);
    check(segIdx == 1'b1, "R2 falling edge selects segment 1", {31'd0, segIdx}, 32'd1);
    checkPlay(10, 11, 3, "R3 R7 falling trigger ramp step 3");
  endtask

  task automatic testTrigRise();
    doTrig(1'b1);
    check(segIdx == 1'b0, "R2 rising edge selects segment 0", {31'd0, segIdx}, 32'd0);
    checkPlay(0, 3, 1, "R3 rising trigger ramp");
  endtask

  task automatic testStepZero();
    wrReg(2'd1, mkSeg(0, 4, 5, 1));
    doUpdate();
    checkPlay(4, 5, 0, "R7 step 0 as 1");
  endtask

  task automatic testBadMode();
    wrReg(2'd1, mkSeg(1, 4, 5, 3));
    doUpdate();
    @(negedge clk);
    check(!playActive && !playDone, "R9 mode 3 idle", {30'd0, playActive, playDone}, 32'd0);
    repeat (3) @(negedge clk);
    check(!playActive, "R9 still idle", {31'd0, playActive}, 32'd0);
  endtask

  task automatic testDisable();
    logic [31:0] v;
    wrReg(2'd1, mkSeg(1, 0, 0, 1));
    wrReg(2'd0, 32'h0);
    doUpdate();
    @(negedge clk);
    check(!playActive, "R6 disabled stays idle", {31'd0, playActive}, 32'd0);
    rdReg(2'd3, v);
    check(v == 32'd0, "R6 ignored write left memory unchanged", v, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLoad();
    testShadow();
    testUpdatePlay();
    testIgnored();
    testTrigFall();
    testTrigRise();
    testStepZero();
    testBadMode();
    testDisable();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: all requirements, actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule